// File: doc/BRIEF.md
# Packed-Lane Saturating Add/Subtract Unit

This unit adds or subtracts two 64-bit words treated as a row of independent packed lanes. One lane-size control divides the word into eight 8-bit, four 16-bit or two 32-bit lanes. A mode control picks what happens when a lane overflows: it wraps modulo the lane width, it is clamped to the signed limits, or it is clamped to the unsigned limits. Every lane is computed in the same cycle.

The datapath is a single 64-bit carry chain built from 8-bit slices. At each slice that begins a lane, the incoming carry is cut and replaced by the operation's carry-in. A subtraction is formed as A plus the inverted B, with a carry-in of one at the bottom of every lane. The saturation stage takes the overflow flags from the top slice of each lane and applies them to every slice of that lane.

The result and a valid flag are registered. A result appears one clock after its operands are presented with `in_valid` high.

Top module: `simd_sat_addsub`

## Requirements
- R1: The result register loads one clock after a cycle with `in_valid` high, and `out_valid` then goes high. After a cycle with `in_valid` low, `out_valid` is low and `result` keeps its previous value, whatever the operand inputs do.
- R2: While `rst` is high at a clock edge, `out_valid` and `result` become zero.
- R3: `lane_sz` selects the lane width: 2'b00 gives 8 bits, 2'b01 gives 16 bits and 2'b10 gives 32 bits. 2'b11 behaves exactly as 2'b00.
- R4: With `sub`=0 and `sat_mode`=2'b00, each lane of `result` is (A+B) modulo 2^width. No carry passes into the next lane.
- R5: With `sub`=1 and `sat_mode`=2'b00, each lane is (A-B) modulo 2^width. No borrow passes into the next lane.
- R6: With `sat_mode`=2'b01, lanes are two's-complement numbers. A lane result above the signed maximum becomes 0 followed by all ones. A lane result below the signed minimum becomes 1 followed by all zeros.
- R7: With `sat_mode`=2'b10 and `sub`=0, a lane whose unsigned sum exceeds 2^width-1 becomes all ones.
- R8: With `sat_mode`=2'b10 and `sub`=1, a lane where B is greater than A (unsigned) becomes zero.
- R9: `sat_mode`=2'b11 is reserved and behaves exactly as wraparound (2'b00).
- R10: In either saturating mode, a lane that does not overflow holds the exact sum or difference. This holds even when other lanes in the same word saturate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| sub | input | 1 | 1 = subtract B from A, 0 = add |
| lane_sz | input | 2 | Lane width select (00/11 = 8, 01 = 16, 10 = 32) |
| sat_mode | input | 2 | 00/11 = wrap, 01 = signed clamp, 10 = unsigned clamp |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 64 | Packed lane results |

## Verification
A carry cut at the wrong slice shows up on the very next valid output. It makes a lane that should be isolated pick up or lose a one at its lowest bit, and it is exposed by operand patterns that generate carries at every slice boundary. A wrong lane owner in the saturation stage broadcasts the flags of the wrong slice. The result is a partially clamped lane, for example 0x7F in a byte that should hold 0xFF, and it is seen one clock after the operands. A bad carry-in for subtraction makes every lane off by one in that same cycle. This is caught as soon as any subtract vector with nonzero operands is issued.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DATA_W  = 64;
  localparam int SLICE_W = 8;
  localparam int NSLICE  = DATA_W / SLICE_W;

  typedef enum logic [1:0] {
    LSZ_8    = 2'b00,
    LSZ_16   = 2'b01,
    LSZ_32   = 2'b10,
    LSZ_8ALT = 2'b11
  } lane_sz_e;

  typedef enum logic [1:0] {
    MODE_WRAP = 2'b00,
    MODE_SSAT = 2'b01,
    MODE_USAT = 2'b10,
    MODE_RSVD = 2'b11
  } sat_mode_e;
endpackage

// File: rtl/simd_lane_map.sv
// Decodes the lane-size select into a per-slice "lane starts here" mask
// and the OR-mask that maps a slice to the top slice of its lane.
module simd_lane_map #(
  parameter int NSLICE = 8
) (
  input  logic [1:0]        lane_sz,
  output logic [NSLICE-1:0] cut,
  output logic [1:0]        own_mask
);
  always_comb begin
    case (lane_sz)
      2'b01:   own_mask = 2'd1;
      2'b10:   own_mask = 2'd3;
      default: own_mask = 2'd0;
    endcase
  end

  for (genvar g = 0; g < NSLICE; g++) begin : g_cut
    assign cut[g] = ((g & int'(own_mask)) == 0);
  end
endmodule

// File: rtl/simd_seg_adder.sv
// Slice-wise carry chain; the carry is replaced by the operation carry-in
// at every slice where a lane begins.
module simd_seg_adder #(
  parameter int SLICE_W = 8,
  parameter int NSLICE  = 8,
  localparam int DW     = SLICE_W * NSLICE
) (
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     b,
  input  logic              sub,
  input  logic [NSLICE-1:0] cut,
  output logic [DW-1:0]     beff,
  output logic [DW-1:0]     sum,
  output logic [NSLICE-1:0] cout
);
  logic [NSLICE-1:0] cin;

  assign beff = sub ? ~b : b;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    if (g == 0) begin : g_lsb
      assign cin[g] = sub;
    end else begin : g_mid
      assign cin[g] = cut[g] ? sub : cout[g-1];
    end
    assign {cout[g], sum[g*SLICE_W +: SLICE_W]} =
        {1'b0, a[g*SLICE_W +: SLICE_W]} +
        {1'b0, beff[g*SLICE_W +: SLICE_W]} +
        {{SLICE_W{1'b0}}, cin[g]};
  end
endmodule

// File: rtl/simd_sat_sel.sv
// Per-slice clamp: overflow flags are computed at every slice as if it were
// a lane top, then each slice reads the flags of its own lane's top slice.
module simd_sat_sel #(
  parameter int SLICE_W = 8,
  parameter int NSLICE  = 8,
  localparam int DW     = SLICE_W * NSLICE
) (
  input  logic [DW-1:0]     a,
  input  logic [DW-1:0]     beff,
  input  logic [DW-1:0]     sum,
  input  logic [NSLICE-1:0] cout,
  input  logic              sub,
  input  logic [1:0]        sat_mode,
  input  logic [1:0]        own_mask,
  output logic [DW-1:0]     res
);
  import simd_pkg::*;

  logic [NSLICE-1:0] pos_ovf, neg_ovf, u_hi, u_lo;

  for (genvar g = 0; g < NSLICE; g++) begin : g_flag
    localparam int MSB = g*SLICE_W + SLICE_W - 1;
    logic sovf;
    assign sovf       = (a[MSB] == beff[MSB]) && (sum[MSB] != a[MSB]);
    assign pos_ovf[g] = sovf && !a[MSB];
    assign neg_ovf[g] = sovf &&  a[MSB];
    assign u_hi[g]    = !sub && cout[g];
    assign u_lo[g]    =  sub && !cout[g];
  end

  for (genvar g = 0; g < NSLICE; g++) begin : g_sel
    int           own;
    logic         top;
    logic [SLICE_W-1:0] sl;
    always_comb begin
      own = g | int'(own_mask);
      top = (own == g);
      sl  = sum[g*SLICE_W +: SLICE_W];
      case (sat_mode_e'(sat_mode))
        MODE_SSAT: begin
          if (pos_ovf[own])
            sl = top ? {1'b0, {(SLICE_W-1){1'b1}}} : {SLICE_W{1'b1}};
          else if (neg_ovf[own])
            sl = top ? {1'b1, {(SLICE_W-1){1'b0}}} : {SLICE_W{1'b0}};
        end
        MODE_USAT: begin
          if (u_hi[own])      sl = {SLICE_W{1'b1}};
          else if (u_lo[own]) sl = {SLICE_W{1'b0}};
        end
        default: ;
      endcase
    end
    assign res[g*SLICE_W +: SLICE_W] = sl;
  end
endmodule

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub #(
  parameter int SLICE_W = simd_pkg::SLICE_W,
  parameter int NSLICE  = simd_pkg::NSLICE,
  localparam int DW     = SLICE_W * NSLICE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          sub,
  input  logic [1:0]    lane_sz,
  input  logic [1:0]    sat_mode,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  logic [NSLICE-1:0] cut, cout;
  logic [1:0]        own_mask;
  logic [DW-1:0]     beff, sum, res_d;

  simd_lane_map #(.NSLICE(NSLICE)) u_map (
    .lane_sz(lane_sz), .cut(cut), .own_mask(own_mask)
  );

  simd_seg_adder #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_add (
    .a(op_a), .b(op_b), .sub(sub), .cut(cut),
    .beff(beff), .sum(sum), .cout(cout)
  );

  simd_sat_sel #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_sat (
    .a(op_a), .beff(beff), .sum(sum), .cout(cout), .sub(sub),
    .sat_mode(sat_mode), .own_mask(own_mask), .res(res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_d;
    end
  end
endmodule

// File: rtl/simd_sat_addsub_chk.sv
module simd_sat_addsub_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [63:0] op_a,
  input logic [63:0] op_b,
  input logic        sub,
  input logic [1:0]  lane_sz,
  input logic [1:0]  sat_mode,
  input logic        out_valid,
  input logic [63:0] result
);
  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == 64'd0));

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  a_r4_wrap32_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sub && lane_sz == 2'b10 && sat_mode == 2'b00) |=>
      result[31:0] == $past(op_a[31:0] + op_b[31:0]));

  for (genvar g = 0; g < 8; g++) begin : g_byte
    a_r7_usat_add_ge: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !sub && lane_sz == 2'b00 && sat_mode == 2'b10) |=>
        result[g*8 +: 8] >= $past(op_a[g*8 +: 8]));
    a_r8_usat_sub_le: assert property (@(posedge clk) disable iff (rst)
      (in_valid && sub && lane_sz == 2'b00 && sat_mode == 2'b10) |=>
        result[g*8 +: 8] <= $past(op_a[g*8 +: 8]));
  end

  a_r6_ssat32_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_sz == 2'b10 && sat_mode == 2'b01 &&
     (op_a[63] == (op_b[63] ^ sub))) |=> result[63] == $past(op_a[63]));
endmodule

bind simd_sat_addsub simd_sat_addsub_chk i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .sub(sub), .lane_sz(lane_sz), .sat_mode(sat_mode),
  .out_valid(out_valid), .result(result)
);

// File: tb/test_simd_sat_addsub.sv
module test_simd_sat_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        sub = 1'b0;
  logic [1:0]  lane_sz = 2'b00, sat_mode = 2'b00;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_sat_addsub i_simd_sat_addsub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub(sub), .lane_sz(lane_sz), .sat_mode(sat_mode),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic s, input logic [1:0] lsz,
                                        input logic [1:0] md);
    int w;
    logic [63:0] r;
    longint msk, ua, ub, sa, sb, v;
    w = (lsz == 2'b01) ? 16 : (lsz == 2'b10) ? 32 : 8;
    msk = (longint'(1) <<< w) - 1;
    r = '0;
    for (int l = 0; l < 64 / w; l++) begin
      ua = longint'(a >> (l*w)) & msk;
      ub = longint'(b >> (l*w)) & msk;
      sa = (ua > (msk >>> 1)) ? ua - msk - 1 : ua;
      sb = (ub > (msk >>> 1)) ? ub - msk - 1 : ub;
      if (md == 2'b01) begin
        v = s ? sa - sb : sa + sb;
        if (v > (msk >>> 1)) v = msk >>> 1;
        if (v < -(msk >>> 1) - 1) v = -(msk >>> 1) - 1;
      end else if (md == 2'b10) begin
        v = s ? ua - ub : ua + ub;
        if (v < 0) v = 0;
        if (v > msk) v = msk;
      end else begin
        v = s ? ua - ub : ua + ub;
      end
      r = r | (64'(v & msk) << (l*w));
    end
    return r;
  endfunction

  function automatic string tag_of(input logic s, input logic [1:0] md);
    case (md)
      2'b01:   return "R6";
      2'b10:   return s ? "R8" : "R7";
      2'b11:   return "R9";
      default: return s ? "R5" : "R4";
    endcase
  endfunction

  task automatic expect_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic s,
                     input logic [1:0] lsz, input logic [1:0] md, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; sub = s; lane_sz = lsz; sat_mode = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_eq(tag, result, model(a, b, s, lsz, md));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R2: reset state
    expect_eq("R2", {63'd0, out_valid}, 64'd0);
    expect_eq("R2", result, 64'd0);
    rst = 1'b0;

    // R1: valid timing and hold
    @(negedge clk);
    op_a = 64'h1; op_b = 64'h2; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_eq("R1", {63'd0, out_valid}, 64'd1);
    held = result;
    op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h1234;
    @(negedge clk);
    expect_eq("R1", {63'd0, out_valid}, 64'd0);
    expect_eq("R1", result, held);

    // R4/R5: carries and borrows stay inside lanes
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 2'b00, 2'b00, "R4");
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 1'b0, 2'b01, 2'b00, "R4");
    run(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 1'b1, 2'b10, 2'b00, "R5");
    run(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 1'b1, 2'b00, 2'b00, "R5");
    // R3: reserved lane size equals 8-bit lanes
    run(64'hFF80_7F01_00FF_807F, 64'h0180_0101_FF01_7F01, 1'b0, 2'b11, 2'b01, "R3");
    expect_eq("R3", result, model(64'hFF80_7F01_00FF_807F, 64'h0180_0101_FF01_7F01, 1'b0, 2'b00, 2'b01));
    // R6: signed clamps at every width
    run(64'h7F80_7F80_7F80_7F80, 64'h0180_0180_0180_0180, 1'b0, 2'b00, 2'b01, "R6");
    run(64'h7FFF_8000_7FFF_8000, 64'hFFFF_0001_0001_FFFF, 1'b1, 2'b01, 2'b01, "R6");
    run(64'h7FFF_FFFF_8000_0000, 64'h0000_0001_0000_0001, 1'b0, 2'b10, 2'b01, "R6");
    expect_eq("R6", result, 64'h7FFF_FFFF_8000_0001);
    run(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 1'b1, 2'b10, 2'b01, "R6");
    expect_eq("R6", result, 64'h8000_0000_7FFF_FFFF);
    // R7/R8: unsigned clamps
    run(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001, 1'b0, 2'b10, 2'b10, "R7");
    expect_eq("R7", result, 64'hFFFF_FFFF_0000_0002);
    run(64'h0000_0005_0001_0000, 64'h0000_0006_0000_0001, 1'b1, 2'b01, 2'b10, "R8");
    expect_eq("R8", result, 64'h0000_0000_0001_0000);
    // R9: reserved mode wraps
    run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, 2'b00, 2'b11, "R9");
    expect_eq("R9", result, 64'd0);
    // R10: mixed lanes, non-overflowing ones exact
    run(64'h10FF_2000_3000_4000, 64'h0101_0001_0002_0003, 1'b0, 2'b00, 2'b10, "R10");
    expect_eq("R10", result, 64'h11FF_2001_3002_4003);
    run(64'h0105_7F10, 64'h0203_0120, 1'b0, 2'b00, 2'b01, "R10");
    expect_eq("R10", result, 64'h0308_7F30);

    // Random mix across all sizes, modes and directions
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra, rb;
      logic        rs;
      logic [1:0]  rl, rm;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (($urandom % 4) == 0) ra = ra | 64'h8080_8080_8080_8080;
      if (($urandom % 4) == 0) rb = rb & 64'h7F7F_7F7F_7F7F_7F7F;
      rs = 1'($urandom);
      rl = 2'($urandom);
      rm = 2'($urandom);
      run(ra, rb, rs, rl, rm, tag_of(rs, rm));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule